// File: doc/BRIEF.md
# Converter Output Formatter with Calibration Hold

This block sits between the digitizing core of a 10-bit video converter and the output pads. Each clock the core delivers a result split into an upper (coarse) part and a lower (fine) part. The block delays the result through a fixed pipeline and registers it. It then shapes the registered word for the pads: normal data with optional inversion of the low field and of the top bit, or a fixed alternating test word. It also produces a pad drive enable from an active-low enable pin.

While the converter calibrates, its fine comparators are busy for a few cycles. A falling edge on the calibration strobe starts a countdown. After a fixed delay the fine field of the output register is frozen for a fixed number of edges, while the coarse field keeps moving. A new falling edge on the strobe restarts the countdown, even if a freeze is already pending or running.

Top module: `adc_out_formatter`

## Requirements
- R1: With `live_en`=1 and both inversion pins low, `data_out` is the straight binary code {coarse, fine}: coarse occupies bits 9:5 and fine bits 4:0, so all-ones is 1023 and all-zeros is 0.
- R2: A code presented on `coarse_in`/`fine_in` at rising edge k is the registered word after edge k+3 (PIPE_LAT=3), unless R3 freezes its fine part.
- R3: A trigger edge is a rising edge at which `cal_in` is 0 and was 1 at the previous edge. If the most recent trigger before edge e was at edge t, and e-t is 7, 8, 9 or 10, then the fine field keeps its value across edge e.
- R4: The coarse field keeps following R2 at every edge, including the frozen edges of R3.
- R5: A trigger edge that falls inside a pending or running freeze restarts the countdown from that edge. The freeze of the earlier trigger ends at once.
- R6: With `live_en`=1, `lo_inv`=1 inverts `data_out[8:0]` and leaves bit 9 unchanged.
- R7: With `live_en`=1, `msb_inv`=1 inverts `data_out[9]` and leaves bits 8:0 unchanged.
- R8: With `live_en`=0, `data_out[8:0]` is 9'h155 (bit 0 = 1, bits alternate), or 9'h0AA when `lo_inv`=1, whatever the registered data.
- R9: With `live_en`=0, `data_out[9]` equals `msb_inv`.
- R10: `drive_en` is the inverse of `oe_n` and follows it with no clock edge.
- R11: While reset is held, and through the two synchronizing edges after release, the registered word is 0 and no freeze is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coarse_in | input | 5 | Upper part of the core result |
| fine_in | input | 5 | Lower part of the core result |
| cal_in | input | 1 | Calibration strobe; its falling edge is the trigger |
| live_en | input | 1 | 1 selects converted data, 0 the fixed test word |
| lo_inv | input | 1 | Inverts bits 8:0 of the output |
| msb_inv | input | 1 | Inverts bit 9 (or sets it in test word mode) |
| oe_n | input | 1 | Active-low output enable |
| data_out | output | 10 | Formatted output word |
| drive_en | output | 1 | Pad drive enable, high drives the pads |

## Verification
The bench counts rising edges from the first edge after the internal reset release. It predicts the registered word after edge e as the input of edge e-3. The fine part of that prediction is held when e lies 7 to 10 edges after the latest trigger. Both predictions are compared half a cycle after edge e. Output shaping and the drive enable add no cycle, so they are checked in the same half-cycle against that prediction. The drive enable is also toggled between edges and read 1 ns later. An odd multiplier sweeps all 1024 codes, mode pins cycle through all combinations, and triggers are placed singly, back to back, and inside pending and active freezes.

// File: rtl/ofm_pkg.sv
package ofm_pkg;

  localparam int unsigned OFM_COARSE_W = 5;
  localparam int unsigned OFM_FINE_W   = 5;
  localparam int unsigned OFM_PIPE_LAT = 3;
  localparam int unsigned OFM_CAL_DLY  = 7;
  localparam int unsigned OFM_CAL_HOLD = 4;

  // Word with ones on even bit positions, zeros on odd ones.
  function automatic logic [63:0] alt_pattern();
    logic [63:0] r;
    for (int i = 0; i < 64; i++) begin
      r[i] = (i % 2 == 0);
    end
    return r;
  endfunction

endpackage

// File: rtl/ofm_cal_hold.sv
module ofm_cal_hold #(
  parameter int unsigned DLY  = ofm_pkg::OFM_CAL_DLY,
  parameter int unsigned HOLD = ofm_pkg::OFM_CAL_HOLD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_in,
  output logic hold_o
);

  localparam int unsigned MAXC  = DLY + HOLD - 1;
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic             cal_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             trig;
  logic             cnt_busy;

  always_comb begin
    trig     = cal_q & ~cal_in;
    cnt_busy = (cnt_q != '0);
    hold_o   = cnt_busy && (cnt_q <= CNT_W'(HOLD));
    if (trig) begin
      cnt_nxt = CNT_W'(MAXC);
    end else if (cnt_busy) begin
      cnt_nxt = cnt_q - CNT_W'(1);
    end else begin
      cnt_nxt = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      cal_q <= cal_in;
      cnt_q <= cnt_nxt;
    end
  end

  // R5
  restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !hold_o);

  // R3
  hold_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> (cnt_q == CNT_W'(HOLD)));

endmodule

// File: rtl/ofm_delay_line.sv
module ofm_delay_line #(
  parameter int unsigned W     = ofm_pkg::OFM_COARSE_W + ofm_pkg::OFM_FINE_W,
  parameter int unsigned DEPTH = ofm_pkg::OFM_PIPE_LAT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] stage_nxt;
    if (i == 0) begin : g_head
      always_comb stage_nxt = din;
    end else begin : g_body
      always_comb stage_nxt = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[i] <= '0;
      end else begin
        stage_q[i] <= stage_nxt;
      end
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/ofm_out_reg.sv
module ofm_out_reg #(
  parameter int unsigned CW = ofm_pkg::OFM_COARSE_W,
  parameter int unsigned FW = ofm_pkg::OFM_FINE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] coarse_d,
  input  logic [FW-1:0] fine_d,
  input  logic          hold_i,
  output logic [CW-1:0] coarse_q,
  output logic [FW-1:0] fine_q
);

  logic [CW-1:0] coarse_nxt;
  logic [FW-1:0] fine_nxt;
  logic          fine_load;

  always_comb begin
    fine_load  = ~hold_i;
    coarse_nxt = coarse_d;
    fine_nxt   = fine_load ? fine_d : fine_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
      fine_q   <= '0;
    end else begin
      coarse_q <= coarse_nxt;
      fine_q   <= fine_nxt;
    end
  end

  // R3
  fine_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(fine_q));

  // R4
  coarse_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (coarse_q == $past(coarse_d)));

endmodule

// File: rtl/ofm_formatter.sv
module ofm_formatter #(
  parameter int unsigned W = ofm_pkg::OFM_COARSE_W + ofm_pkg::OFM_FINE_W
) (
  input  logic         live_en,
  input  logic         lo_inv,
  input  logic         msb_inv,
  input  logic [W-1:0] raw,
  output logic [W-1:0] fmt
);

  localparam logic [63:0]  PAT64 = ofm_pkg::alt_pattern();
  localparam logic [W-2:0] PAT   = PAT64[W-2:0];

  logic [W-2:0] low_src;
  logic         top_src;

  always_comb begin
    low_src = live_en ? raw[W-2:0] : PAT;
    top_src = live_en ? raw[W-1]   : 1'b0;
    fmt     = {top_src ^ msb_inv, low_src ^ {(W-1){lo_inv}}};
  end

endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter #(
  parameter int unsigned COARSE_W = ofm_pkg::OFM_COARSE_W,
  parameter int unsigned FINE_W   = ofm_pkg::OFM_FINE_W,
  parameter int unsigned PIPE_LAT = ofm_pkg::OFM_PIPE_LAT,
  parameter int unsigned CAL_DLY  = ofm_pkg::OFM_CAL_DLY,
  parameter int unsigned CAL_HOLD = ofm_pkg::OFM_CAL_HOLD
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [COARSE_W-1:0]          coarse_in,
  input  logic [FINE_W-1:0]            fine_in,
  input  logic                         cal_in,
  input  logic                         live_en,
  input  logic                         lo_inv,
  input  logic                         msb_inv,
  input  logic                         oe_n,
  output logic [COARSE_W+FINE_W-1:0]   data_out,
  output logic                         drive_en
);

  localparam int unsigned W = COARSE_W + FINE_W;

  logic          rst_meta;
  logic          rst_sync;
  logic [W-1:0]  pipe_out;
  logic          hold;
  logic [COARSE_W-1:0] coarse_q;
  logic [FINE_W-1:0]   fine_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  ofm_delay_line #(.W(W), .DEPTH(PIPE_LAT)) i_delay (
    .clk   (clk),
    .rst_n (rst_sync),
    .din   ({coarse_in, fine_in}),
    .dout  (pipe_out)
  );

  ofm_cal_hold #(.DLY(CAL_DLY), .HOLD(CAL_HOLD)) i_cal_hold (
    .clk    (clk),
    .rst_n  (rst_sync),
    .cal_in (cal_in),
    .hold_o (hold)
  );

  ofm_out_reg #(.CW(COARSE_W), .FW(FINE_W)) i_out_reg (
    .clk      (clk),
    .rst_n    (rst_sync),
    .coarse_d (pipe_out[W-1:FINE_W]),
    .fine_d   (pipe_out[FINE_W-1:0]),
    .hold_i   (hold),
    .coarse_q (coarse_q),
    .fine_q   (fine_q)
  );

  ofm_formatter #(.W(W)) i_fmt (
    .live_en (live_en),
    .lo_inv  (lo_inv),
    .msb_inv (msb_inv),
    .raw     ({coarse_q, fine_q}),
    .fmt     (data_out)
  );

  assign drive_en = ~oe_n;

  // R8
  pattern_fixed_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (!live_en && $past(!live_en) && $stable(lo_inv)) |-> $stable(data_out[W-2:0]));

endmodule

// File: tb/test_adc_out_formatter.sv
module test_adc_out_formatter;

  localparam int N = 2100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] coarse_in;
  logic [4:0] fine_in;
  logic       cal_in;
  logic       live_en;
  logic       lo_inv;
  logic       msb_inv;
  logic       oe_n;
  logic [9:0] data_out;
  logic       drive_en;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  adc_out_formatter i_adc_out_formatter (
    .clk       (clk),
    .rst_n     (rst_n),
    .coarse_in (coarse_in),
    .fine_in   (fine_in),
    .cal_in    (cal_in),
    .live_en   (live_en),
    .lo_inv    (lo_inv),
    .msb_inv   (msb_inv),
    .oe_n      (oe_n),
    .data_out  (data_out),
    .drive_en  (drive_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] code_at(int e);
    return 10'((e * 293 + 11) % 1024);
  endfunction

  function automatic logic cal_at(int e);
    if (e < 0) return 1'b0;
    if (e == 100 || e == 101) return 1'b1;            // trigger at 102
    if (e == 300 || e == 305) return 1'b1;            // triggers 301, 306 (pending restart)
    if (e == 499 || e == 508) return 1'b1;            // triggers 500, 509 (active restart)
    if (e == 700 || e == 701 || e == 703) return 1'b1; // triggers 702, 704
    if (e >= 900 && e < 2000 && (e % 37) == 0) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [9:0] shape(logic [9:0] raw, logic live, logic li, logic mi);
    if (live) return raw ^ {mi, {9{li}}};
    return {mi, 9'h155 ^ {9{li}}};
  endfunction

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog R2 actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] exp_fine;
    logic [4:0] exp_coarse;
    logic [9:0] exp_out;
    int         last_trig;
    logic       hold;

    rst_n = 1'b0; coarse_in = 5'h1f; fine_in = 5'h1f; cal_in = 1'b0;
    live_en = 1'b1; lo_inv = 1'b0; msb_inv = 1'b0; oe_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 reset word", 32'(data_out), 32'h0);
    chk("R10 disabled", 32'(drive_en), 32'h0);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R11 after sync edges", 32'(data_out), 32'h0);

    exp_fine  = '0;
    last_trig = -100;
    for (int e = 0; e < N; e++) begin
      coarse_in = code_at(e)[9:5];
      fine_in   = code_at(e)[4:0];
      cal_in    = cal_at(e);
      live_en   = (((e >> 4) % 5) != 0);
      lo_inv    = e[5];
      msb_inv   = e[6];
      oe_n      = e[0];
      @(posedge clk);
      @(negedge clk);

      hold = ((e - last_trig) >= 7) && ((e - last_trig) <= 10);
      if (!hold) exp_fine = (e >= 3) ? code_at(e - 3)[4:0] : 5'h0;
      exp_coarse = (e >= 3) ? code_at(e - 3)[9:5] : 5'h0;
      if (cal_at(e - 1) && !cal_at(e)) last_trig = e;

      exp_out = shape({exp_coarse, exp_fine}, live_en, lo_inv, msb_inv);
      if (live_en) begin
        if (hold)
          chk("R3 fine held", 32'(data_out[4:0] ^ {5{lo_inv}}), 32'(exp_fine));
        else if ((e >= 300 && e < 330) || (e >= 500 && e < 530))
          chk("R5 fine after restart", 32'(data_out[4:0] ^ {5{lo_inv}}), 32'(exp_fine));
        else
          chk("R2 fine latency", 32'(data_out[4:0] ^ {5{lo_inv}}), 32'(exp_fine));
        if (hold)
          chk("R4 coarse during hold", 32'(data_out[8:5] ^ {4{lo_inv}}), 32'(exp_coarse[3:0]));
        if (lo_inv)
          chk("R6 low inversion", 32'(data_out), 32'(exp_out));
        else if (msb_inv)
          chk("R7 msb inversion", 32'(data_out), 32'(exp_out));
        else
          chk("R1 straight binary", 32'(data_out), 32'(exp_out));
      end else begin
        chk("R8 test word", 32'(data_out[8:0]), 32'(exp_out[8:0]));
        chk("R9 test msb", 32'(data_out[9]), 32'(msb_inv));
      end
      chk("R10 drive enable", 32'(drive_en), 32'(!oe_n));
      if ((e % 64) == 13) begin
        oe_n = ~oe_n;
        #1;
        chk("R10 async enable", 32'(drive_en), 32'(!oe_n));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule